// File: doc/BRIEF.md
# Linked-List DMA Source Sequencer

This block runs the source side of a memory-to-device DMA channel. After a start strobe it either moves a preset run of quadwords (linear mode) or walks a list of 128-bit descriptors held in memory (list mode). Each descriptor gives a quadword count, an address, a kind code and an interrupt flag. The kind code decides where the payload comes from and where the next descriptor sits. For every payload the block drives a simple valid/ready data-mover port with one 16-byte address per quadword.

The descriptor memory is reached through a plain read port with one cycle of latency, so fetching one descriptor takes two cycles. A transfer ends on a terminating kind code, or on a flagged descriptor while descriptor interrupts are enabled. When it ends, the busy (start) bit drops and a one-cycle done interrupt pulse is raised. The descriptor pointer and the payload pointer stay readable on output ports.

Top module: `dcs_chain_seq`

## Requirements
- R1: After reset, busy_o, done_irq_o, mem_req_o and mv_valid_o are all low.
- R2: In linear mode (chain_mode_i=0 at start) with a nonzero qwc_init_i, the block moves exactly that many quadwords. The addresses are madr_init_i, +16, +32 and so on. It then finishes without issuing any descriptor read.
- R3: In list mode, each descriptor costs two cycles. In the first cycle the block asserts mem_req_o with mem_addr_o equal to the descriptor pointer. In the second cycle it captures mem_rdata_i, with count in bits [15:0], kind in bits [30:28], flag in bit 31 and address in bits [63:32]. Kind codes are: 0 ref-end, 1 count, 2 jump, 3 ref, 4 ref-stall, 7 end, and 5/6 act as end.
- R4: Kind 1 (count): the payload starts at descriptor+16, and the next descriptor is at descriptor+16+count*16.
- R5: Kind 2 (jump): the payload starts at descriptor+16, and the next descriptor is at the address field.
- R6: Kinds 3 and 4 (ref, ref-stall): the payload starts at the address field, the next descriptor is at descriptor+16, and the list continues.
- R7: Kind 0 (ref-end): the payload starts at the address field, the descriptor pointer becomes descriptor+16, and the transfer ends after the payload.
- R8: Kind 7 (end): the payload starts at descriptor+16, the descriptor pointer moves past the payload, and the transfer ends after the payload.
- R9: A descriptor with the flag set ends the transfer after its payload when tag_irq_en_i was high at start. With tag_irq_en_i low, the flag has no effect.
- R10: A descriptor with count zero moves no quadword and goes straight to the pointer update.
- R11: The transfer finishes in one clock edge. On that edge busy_o falls and done_irq_o is high for exactly one cycle.
- R12: While mv_valid_o is high and mv_ready_i is low, mv_addr_o holds its value.
- R13: A start strobe while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| chain_mode_i | input | 1 | 1 = list mode, 0 = linear mode |
| tag_irq_en_i | input | 1 | Descriptor interrupt enable, latched at start |
| madr_init_i | input | AW | Payload address preset (linear mode) |
| tadr_init_i | input | AW | First descriptor address (list mode) |
| qwc_init_i | input | CW | Quadword count preset (linear mode) |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | AW | Descriptor read address |
| mem_rdata_i | input | 128 | Descriptor data, valid the cycle after a request |
| mv_valid_o | output | 1 | Quadword move request |
| mv_addr_o | output | AW | Address of the quadword to move |
| mv_ready_i | input | 1 | Data mover accepts the quadword |
| busy_o | output | 1 | Start bit, high while a transfer runs |
| done_irq_o | output | 1 | One-cycle done interrupt |
| tadr_o | output | AW | Current descriptor pointer |
| madr_o | output | AW | Current payload pointer |
| qwc_o | output | CW | Quadwords left in the current payload |

## Verification
The assertions assume the descriptor memory always returns data exactly one cycle after mem_req_o. The bench memory model is written that way, with a registered read on every request. The assertions also assume that descriptor counts never make the address arithmetic wrap. All bench descriptors and payloads use small addresses well below the address width. The handshake checks take mv_ready_i to be a free-running input. The bench drives it from a registered stall pattern that changes only on the clock edge.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int unsigned TAG_W      = 128;
    localparam int unsigned QW_SHIFT   = 4;
    localparam int unsigned F_CNT_LSB  = 0;
    localparam int unsigned F_CNT_W    = 16;
    localparam int unsigned F_KIND_LSB = 28;
    localparam int unsigned F_FLAG_BIT = 31;
    localparam int unsigned F_ADDR_LSB = 32;
    localparam int unsigned F_ADDR_W   = 32;

    typedef enum logic [2:0] {
        K_REFEND  = 3'd0,
        K_COUNT   = 3'd1,
        K_JUMP    = 3'd2,
        K_REF     = 3'd3,
        K_REFSTL  = 3'd4,
        K_RSVD5   = 3'd5,
        K_RSVD6   = 3'd6,
        K_END     = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_TAG_REQ = 2'd1,
        S_TAG_CAP = 2'd2,
        S_XFER    = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dcs_tag_unpack.sv
module dcs_tag_unpack
    import dcs_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic [TAG_W-1:0] tag_i,
    output logic [CW-1:0]    cnt_o,
    output kind_e            kind_o,
    output logic             flag_o,
    output logic [AW-1:0]    addr_o
);

    localparam int unsigned CNT_KEEP  = (CW < F_CNT_W) ? CW : F_CNT_W;
    localparam int unsigned ADDR_KEEP = (AW < F_ADDR_W) ? AW : F_ADDR_W;

    logic [F_CNT_W-1:0]  raw_cnt;
    logic [F_ADDR_W-1:0] raw_addr;

    assign raw_cnt  = tag_i[F_CNT_LSB +: F_CNT_W];
    assign raw_addr = tag_i[F_ADDR_LSB +: F_ADDR_W];
    assign kind_o   = kind_e'(tag_i[F_KIND_LSB +: 3]);
    assign flag_o   = tag_i[F_FLAG_BIT];

    generate
        if (CW > CNT_KEEP) begin : g_cnt_wide
            assign cnt_o = {{(CW-CNT_KEEP){1'b0}}, raw_cnt[CNT_KEEP-1:0]};
        end else begin : g_cnt_fit
            assign cnt_o = raw_cnt[CNT_KEEP-1:0];
        end
        if (AW > ADDR_KEEP) begin : g_addr_wide
            assign addr_o = {{(AW-ADDR_KEEP){1'b0}}, raw_addr[ADDR_KEEP-1:0]};
        end else begin : g_addr_fit
            assign addr_o = raw_addr[ADDR_KEEP-1:0];
        end
    endgenerate

endmodule

// File: rtl/dcs_ptr_rules.sv
module dcs_ptr_rules
    import dcs_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic [AW-1:0] tadr_i,
    input  kind_e         kind_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [AW-1:0] addr_i,
    input  logic          flag_i,
    input  logic          flag_en_i,
    output logic [AW-1:0] madr_o,
    output logic [AW-1:0] tadr_o,
    output logic          ends_o
);

    localparam logic [AW-1:0] QW_BYTES = AW'(1) << QW_SHIFT;

    logic [AW-1:0] after_tag;
    logic [AW-1:0] span;

    assign after_tag = tadr_i + QW_BYTES;
    assign span      = AW'(cnt_i) << QW_SHIFT;

    always_comb begin
        madr_o = after_tag;
        tadr_o = after_tag;
        ends_o = 1'b0;
        unique case (kind_i)
            K_COUNT: begin
                madr_o = after_tag;
                tadr_o = after_tag + span;
            end
            K_JUMP: begin
                madr_o = after_tag;
                tadr_o = addr_i;
            end
            K_REF, K_REFSTL: begin
                madr_o = addr_i;
                tadr_o = after_tag;
            end
            K_REFEND: begin
                madr_o = addr_i;
                tadr_o = after_tag;
                ends_o = 1'b1;
            end
            default: begin
                madr_o = after_tag;
                tadr_o = after_tag + span;
                ends_o = 1'b1;
            end
        endcase
        if (flag_i && flag_en_i) begin
            ends_o = 1'b1;
        end
    end

endmodule

// File: rtl/dcs_xfer_step.sv
module dcs_xfer_step
    import dcs_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic [AW-1:0] madr_i,
    input  logic [CW-1:0] cnt_i,
    output logic [AW-1:0] madr_o,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);

    localparam logic [AW-1:0] QW_BYTES = AW'(1) << QW_SHIFT;
    localparam logic [CW-1:0] ONE      = CW'(1);

    assign madr_o = madr_i + QW_BYTES;
    assign cnt_o  = (cnt_i == '0) ? '0 : cnt_i - ONE;
    assign last_o = (cnt_i <= ONE);

endmodule

// File: rtl/dcs_chain_seq.sv
module dcs_chain_seq
    import dcs_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chain_mode_i,
    input  logic              tag_irq_en_i,
    input  logic [AW-1:0]     madr_init_i,
    input  logic [AW-1:0]     tadr_init_i,
    input  logic [CW-1:0]     qwc_init_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [TAG_W-1:0]  mem_rdata_i,
    output logic              mv_valid_o,
    output logic [AW-1:0]     mv_addr_o,
    input  logic              mv_ready_i,
    output logic              busy_o,
    output logic              done_irq_o,
    output logic [AW-1:0]     tadr_o,
    output logic [AW-1:0]     madr_o,
    output logic [CW-1:0]     qwc_o
);

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] tadr;
        logic [AW-1:0] madr;
        logic [CW-1:0] qwc;
        logic          last;
        logic          flag_en;
        logic          irq;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [CW-1:0] tag_cnt;
    kind_e         tag_kind;
    logic          tag_flag;
    logic [AW-1:0] tag_addr;
    logic [AW-1:0] rule_madr;
    logic [AW-1:0] rule_tadr;
    logic          rule_ends;
    logic [AW-1:0] step_madr;
    logic [CW-1:0] step_cnt;
    logic          step_last;

    dcs_tag_unpack #(.AW(AW), .CW(CW)) u_unpack (
        .tag_i  (mem_rdata_i),
        .cnt_o  (tag_cnt),
        .kind_o (tag_kind),
        .flag_o (tag_flag),
        .addr_o (tag_addr)
    );

    dcs_ptr_rules #(.AW(AW), .CW(CW)) u_rules (
        .tadr_i    (r_q.tadr),
        .kind_i    (tag_kind),
        .cnt_i     (tag_cnt),
        .addr_i    (tag_addr),
        .flag_i    (tag_flag),
        .flag_en_i (r_q.flag_en),
        .madr_o    (rule_madr),
        .tadr_o    (rule_tadr),
        .ends_o    (rule_ends)
    );

    dcs_xfer_step #(.AW(AW), .CW(CW)) u_step (
        .madr_i (r_q.madr),
        .cnt_i  (r_q.qwc),
        .madr_o (step_madr),
        .cnt_o  (step_cnt),
        .last_o (step_last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (start_i) begin
                    r_d.tadr    = tadr_init_i;
                    r_d.madr    = madr_init_i;
                    r_d.qwc     = qwc_init_i;
                    r_d.flag_en = tag_irq_en_i;
                    if (chain_mode_i) begin
                        r_d.last  = 1'b0;
                        r_d.state = S_TAG_REQ;
                    end else if (qwc_init_i != '0) begin
                        r_d.last  = 1'b1;
                        r_d.state = S_XFER;
                    end else begin
                        r_d.irq   = 1'b1;
                    end
                end
            end
            S_TAG_REQ: begin
                r_d.state = S_TAG_CAP;
            end
            S_TAG_CAP: begin
                r_d.qwc  = tag_cnt;
                r_d.madr = rule_madr;
                r_d.tadr = rule_tadr;
                r_d.last = rule_ends;
                if (tag_cnt != '0) begin
                    r_d.state = S_XFER;
                end else if (rule_ends) begin
                    r_d.state = S_IDLE;
                    r_d.irq   = 1'b1;
                end else begin
                    r_d.state = S_TAG_REQ;
                end
            end
            S_XFER: begin
                if (mv_ready_i) begin
                    r_d.madr = step_madr;
                    r_d.qwc  = step_cnt;
                    if (step_last) begin
                        if (r_q.last) begin
                            r_d.state = S_IDLE;
                            r_d.irq   = 1'b1;
                        end else begin
                            r_d.state = S_TAG_REQ;
                        end
                    end
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, tadr: '0, madr: '0, qwc: '0,
                     last: 1'b0, flag_en: 1'b0, irq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o  = (r_q.state == S_TAG_REQ);
    assign mem_addr_o = r_q.tadr;
    assign mv_valid_o = (r_q.state == S_XFER);
    assign mv_addr_o  = r_q.madr;
    assign busy_o     = (r_q.state != S_IDLE);
    assign done_irq_o = r_q.irq;
    assign tadr_o     = r_q.tadr;
    assign madr_o     = r_q.madr;
    assign qwc_o      = r_q.qwc;

endmodule

// File: rtl/dcs_chain_seq_chk.sv
module dcs_chain_seq_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic          mv_valid_o,
    input logic [AW-1:0] mv_addr_o,
    input logic          mv_ready_i,
    input logic          busy_o,
    input logic          done_irq_o,
    input logic [CW-1:0] qwc_o
);

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o); // R3

    AST_TAG_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> (busy_o && !mem_req_o && !mv_valid_o)); // R3

    AST_NO_REQ_AND_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && mv_valid_o)); // R3

    AST_FALL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_irq_o); // R11

    AST_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |-> !busy_o); // R11

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o); // R11

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid_o && !mv_ready_i) |=> (mv_valid_o && $stable(mv_addr_o))); // R12

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid_o && mv_ready_i && qwc_o > CW'(1)) |=>
            (mv_valid_o && mv_addr_o == $past(mv_addr_o) + AW'(16))); // R2

endmodule

bind dcs_chain_seq dcs_chain_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_o  (mem_req_o),
    .mv_valid_o (mv_valid_o),
    .mv_addr_o  (mv_addr_o),
    .mv_ready_i (mv_ready_i),
    .busy_o     (busy_o),
    .done_irq_o (done_irq_o),
    .qwc_o      (qwc_o)
);

// File: tb/dcs_chain_seq_tb.sv
module dcs_chain_seq_tb;

    localparam int unsigned AW = 32;
    localparam int unsigned CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          chain_mode_i = 1'b0;
    logic          tag_irq_en_i = 1'b0;
    logic [AW-1:0] madr_init_i = '0;
    logic [AW-1:0] tadr_init_i = '0;
    logic [CW-1:0] qwc_init_i = '0;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic [127:0]  mem_rdata_i = '0;
    logic          mv_valid_o;
    logic [AW-1:0] mv_addr_o;
    logic          mv_ready_i = 1'b0;
    logic          busy_o;
    logic          done_irq_o;
    logic [AW-1:0] tadr_o;
    logic [AW-1:0] madr_o;
    logic [CW-1:0] qwc_o;

    always #5 clk = ~clk;

    dcs_chain_seq #(.AW(AW), .CW(CW)) u_dut (.*);

    logic [127:0] mem [0:127];
    int unsigned  cyc = 0;
    int           errors = 0;
    int           checks = 0;
    logic [AW-1:0] mv_log  [0:31];
    logic [AW-1:0] req_log [0:31];
    int           mv_n = 0;
    int           req_n = 0;
    int           irq_n = 0;
    bit           stall_en = 1'b1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mv_ready_i <= stall_en ? ((cyc % 3) != 0) : 1'b1;
        if (mem_req_o) mem_rdata_i <= mem[mem_addr_o[10:4]];
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mv_valid_o && mv_ready_i) begin
                if (mv_n < 32) mv_log[mv_n] = mv_addr_o;
                mv_n++;
            end
            if (mem_req_o) begin
                if (req_n < 32) req_log[req_n] = mem_addr_o;
                req_n++;
            end
            if (done_irq_o) irq_n++;
        end
    end

    function automatic logic [127:0] mk_tag(input logic [2:0] kind, input logic flag,
                                            input logic [15:0] cnt, input logic [31:0] addr);
        logic [127:0] t;
        t = '0;
        t[15:0]  = cnt;
        t[30:28] = kind;
        t[31]    = flag;
        t[63:32] = addr;
        return t;
    endfunction

    task automatic put(input logic [AW-1:0] a, input logic [127:0] t);
        mem[a[10:4]] = t;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic chain, input logic ie, input logic [AW-1:0] ta,
                          input logic [AW-1:0] ma, input logic [CW-1:0] q);
        mv_n = 0; req_n = 0; irq_n = 0;
        @(negedge clk);
        chain_mode_i = chain; tag_irq_en_i = ie;
        tadr_init_i = ta; madr_init_i = ma; qwc_init_i = q;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (irq_n == 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_moves(input string req, input int n, input logic [AW-1:0] base [0:7]);
        chk(mv_n == n, req, 64'(mv_n), 64'(n));
        for (int i = 0; i < n && i < mv_n; i++) begin
            chk(mv_log[i] == base[i], req, 64'(mv_log[i]), 64'(base[i]));
        end
    endtask

    task automatic test_reset();
        chk(!busy_o && !done_irq_o, "R1", {62'd0, busy_o, done_irq_o}, 64'd0);
        chk(!mem_req_o && !mv_valid_o, "R1", {62'd0, mem_req_o, mv_valid_o}, 64'd0);
    endtask

    task automatic test_linear();
        logic [AW-1:0] e [0:7];
        e = '{32'h100, 32'h110, 32'h120, 0, 0, 0, 0, 0};
        launch(1'b0, 1'b0, 32'h7F0, 32'h100, 16'd3);
        // R13: second strobe while busy, different presets
        madr_init_i = 32'h900; qwc_init_i = 16'd5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk_moves("R2", 3, e);
        chk(req_n == 0, "R2", 64'(req_n), 64'd0);
        chk(irq_n == 1, "R13", 64'(irq_n), 64'd1);
        chk(madr_o == 32'h130, "R13", 64'(madr_o), 64'h130);
        chk(!busy_o, "R11", 64'(busy_o), 64'd0);
    endtask

    task automatic test_count_end();
        logic [AW-1:0] e [0:7];
        e = '{32'h10, 32'h20, 32'h40, 0, 0, 0, 0, 0};
        put(32'h000, mk_tag(3'd1, 1'b0, 16'd2, 32'hDEAD0));
        put(32'h030, mk_tag(3'd7, 1'b0, 16'd1, 32'hBEEF0));
        launch(1'b1, 1'b0, 32'h000, 32'h0, 16'd0);
        wait_done();
        chk_moves("R4", 3, e);
        chk(req_n == 2 && req_log[0] == 32'h000 && req_log[1] == 32'h030, "R3",
            64'(req_log[1]), 64'h30);
        chk(tadr_o == 32'h050, "R8", 64'(tadr_o), 64'h50);
        chk(irq_n == 1, "R11", 64'(irq_n), 64'd1);
    endtask

    task automatic test_jump_ref();
        logic [AW-1:0] e [0:7];
        e = '{32'h90, 32'h300, 32'h310, 32'h400, 0, 0, 0, 0};
        put(32'h080, mk_tag(3'd2, 1'b0, 16'd1, 32'h200));
        put(32'h200, mk_tag(3'd3, 1'b0, 16'd2, 32'h300));
        put(32'h210, mk_tag(3'd0, 1'b0, 16'd1, 32'h400));
        launch(1'b1, 1'b0, 32'h080, 32'h0, 16'd0);
        wait_done();
        chk_moves("R5", 4, e);
        chk(req_n == 3 && req_log[1] == 32'h200, "R5", 64'(req_log[1]), 64'h200);
        chk(req_n == 3 && req_log[2] == 32'h210, "R6", 64'(req_log[2]), 64'h210);
        chk(tadr_o == 32'h220, "R7", 64'(tadr_o), 64'h220);
        chk(irq_n == 1, "R7", 64'(irq_n), 64'd1);
    endtask

    task automatic test_flag(input logic ie);
        logic [AW-1:0] e [0:7];
        e = '{32'h500, 0, 0, 0, 0, 0, 0, 0};
        put(32'h600, mk_tag(3'd4, 1'b1, 16'd1, 32'h500));
        put(32'h610, mk_tag(3'd0, 1'b0, 16'd0, 32'h000));
        launch(1'b1, ie, 32'h600, 32'h0, 16'd0);
        wait_done();
        chk_moves("R9", 1, e);
        if (ie) begin
            chk(req_n == 1 && tadr_o == 32'h610, "R9", 64'(tadr_o), 64'h610);
        end else begin
            chk(req_n == 2 && tadr_o == 32'h620, "R9", 64'(tadr_o), 64'h620);
            chk(mv_n == 1, "R10", 64'(mv_n), 64'd1);
        end
        chk(irq_n == 1 && !busy_o, "R11", 64'(irq_n), 64'd1);
    endtask

    task automatic test_zero();
        put(32'h700, mk_tag(3'd1, 1'b0, 16'd0, 32'hFFF0));
        put(32'h710, mk_tag(3'd5, 1'b0, 16'd0, 32'hFFF0));
        launch(1'b1, 1'b0, 32'h700, 32'h0, 16'd0);
        wait_done();
        chk(mv_n == 0, "R10", 64'(mv_n), 64'd0);
        chk(req_n == 2 && req_log[1] == 32'h710, "R10", 64'(req_log[1]), 64'h710);
        chk(tadr_o == 32'h720, "R8", 64'(tadr_o), 64'h720);
    endtask

    task automatic test_nostall();
        logic [AW-1:0] e [0:7];
        e = '{32'h010, 32'h020, 32'h040, 0, 0, 0, 0, 0};
        stall_en = 1'b0;
        repeat (2) @(negedge clk);
        launch(1'b1, 1'b0, 32'h000, 32'h0, 16'd0);
        wait_done();
        chk_moves("R12", 3, e);
        stall_en = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_linear();
        test_count_end();
        test_jump_ref();
        test_flag(1'b1);
        test_flag(1'b0);
        test_zero();
        test_nostall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule